// File: doc/BRIEF.md
# Write-Strobe Event Synchroniser

This block carries a "word written" event from an external processor bus into the internal system clock domain. The processor bus has no relation to the system clock. The block latches the data word on the rising edge of the processor's write strobe, but only while chip select is active. On that same edge it flips a one-bit flag. The flag is the only signal that crosses into the system domain. There, a short chain of flip-flops samples it. When the two oldest stages of the chain disagree, a new write has arrived. The block then raises a one-cycle valid pulse and registers the latched word onto its data output at the same time.

No signal is driven from both clock domains, because the flag only ever flips and is never cleared. The scheme assumes the system clock runs much faster than the write rate. Writes must be at least four system clock cycles apart.

Top module: `wr_event_sync`

## Requirements
- R1: Every rising edge of `wrStrobe` taken while `chipSel` is 1 counts as one write and produces exactly one valid pulse.
- R2: A rising edge of `wrStrobe` while `chipSel` is 0 has no effect: no valid pulse appears and `dataOut` keeps its value.
- R3: `validOut` goes high in the cycle that follows the third rising edge of `sysClk` after the qualified strobe edge (with the default depth of three sampling stages).
- R4: For writes at least four `sysClk` cycles apart, `validOut` is high for exactly one `sysClk` cycle per write.
- R5: `dataOut` takes the word written in the same cycle that `validOut` is high, and holds its value in every other cycle.
- R6: While `rstN` is 0, `validOut` and `dataOut` are 0. After `rstN` is released, no valid pulse appears until a new write occurs.
- R7: The word is captured on the strobe's rising edge. Changes on `wrData` after that edge do not reach `dataOut`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sysClk | input | 1 | Internal system clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| wrStrobe | input | 1 | Processor write strobe; its rising edge captures data |
| chipSel | input | 1 | Qualifies the strobe; active high |
| wrData | input | DATA_W | Processor write data |
| validOut | output | 1 | One-cycle pulse marking a new word |
| dataOut | output | DATA_W | Most recent written word, system domain |

## Verification
The hardest case to reach is a strobe edge that is ignored. An edge with chip select low, or a change to the data bus while the strobe is still high, leaves the outputs exactly as they were. Nothing moves at the ports to show that the event was seen and dropped. The stimulus therefore places such events between real writes that carry distinct words. Every following cycle is compared against a reference model, so an extra pulse or a corrupted word would show up. Writes at the minimum spacing of four cycles, and a reset issued between writes, stress the pulse count and the clean restart.

// File: rtl/wr_event_sync_pkg.sv
package wr_event_sync_pkg;

  // Strobes passed from the control half to the datapath half.
  typedef struct packed {
    logic capture;  // write-domain qualifier for the holding register
    logic publish;  // system-domain request to load the output word
  } syncStrobes_t;

endpackage

// File: rtl/wr_event_sync_ctrl.sv
module wr_event_sync_ctrl
  import wr_event_sync_pkg::*;
#(
  parameter int SYNC_DEPTH = 3
) (
  input  logic         sysClk,
  input  logic         rstN,
  input  logic         wrStrobe,
  input  logic         chipSel,
  output syncStrobes_t strobes,
  output logic         validOut
);

  localparam int LAST = SYNC_DEPTH - 1;

  logic                  toggleQ;
  logic [SYNC_DEPTH-1:0] syncChain;
  logic                  changeSeen;

  // Write domain: the flag flips on each qualified strobe edge.
  always_ff @(posedge wrStrobe or negedge rstN) begin
    if (!rstN)        toggleQ <= 1'b0;
    else if (chipSel) toggleQ <= ~toggleQ;
  end

  // System domain: sampling chain for the flag.
  for (genvar g = 0; g < SYNC_DEPTH; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge sysClk or negedge rstN) begin
        if (!rstN) syncChain[g] <= 1'b0;
        else       syncChain[g] <= toggleQ;
      end
    end else begin : g_next
      always_ff @(posedge sysClk or negedge rstN) begin
        if (!rstN) syncChain[g] <= 1'b0;
        else       syncChain[g] <= syncChain[g-1];
      end
    end
  end

  assign changeSeen = syncChain[LAST] ^ syncChain[LAST-1];

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= changeSeen;
  end

  assign strobes.capture = chipSel;
  assign strobes.publish = changeSeen;

  // R3: a pulse is only raised when the oldest stage takes a new value.
  a_r3_pulse_follows_stage: assert property (@(posedge sysClk) disable iff (!rstN)
    validOut |-> (syncChain[LAST] != $past(syncChain[LAST])));

  // R4: with writes spaced as required, a pulse never lasts two cycles.
  a_r4_single_cycle: assert property (@(posedge sysClk) disable iff (!rstN)
    validOut |=> !validOut);

  // R6: the first cycle after reset release carries no pulse.
  a_r6_quiet_release: assert property (@(posedge sysClk) disable iff (!rstN)
    $rose(rstN) |-> !validOut);

endmodule

// File: rtl/wr_event_sync_data.sv
module wr_event_sync_data
  import wr_event_sync_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              sysClk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  syncStrobes_t      strobes,
  input  logic              validOut,
  output logic [DATA_W-1:0] dataOut
);

  logic [DATA_W-1:0] holdData;

  // Write domain: capture the word on the qualified strobe edge.
  always_ff @(posedge wrStrobe or negedge rstN) begin
    if (!rstN)                holdData <= '0;
    else if (strobes.capture) holdData <= wrData;
  end

  // System domain: publish the held word with the valid pulse.
  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN)                dataOut <= '0;
    else if (strobes.publish) dataOut <= holdData;
  end

  // R5: the output carries the held word whenever the pulse is up.
  a_r5_load_with_valid: assert property (@(posedge sysClk) disable iff (!rstN)
    validOut |-> (dataOut == $past(holdData)));

  // R5: outside a pulse the output word does not move.
  a_r5_hold_without_valid: assert property (@(posedge sysClk) disable iff (!rstN)
    !validOut |-> $stable(dataOut));

endmodule

// File: rtl/wr_event_sync.sv
module wr_event_sync
  import wr_event_sync_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SYNC_DEPTH = 3
) (
  input  logic              sysClk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic              chipSel,
  input  logic [DATA_W-1:0] wrData,
  output logic              validOut,
  output logic [DATA_W-1:0] dataOut
);

  syncStrobes_t strobes;

  wr_event_sync_ctrl #(.SYNC_DEPTH(SYNC_DEPTH)) u_ctrl (
    .sysClk   (sysClk),
    .rstN     (rstN),
    .wrStrobe (wrStrobe),
    .chipSel  (chipSel),
    .strobes  (strobes),
    .validOut (validOut)
  );

  wr_event_sync_data #(.DATA_W(DATA_W)) u_data (
    .sysClk   (sysClk),
    .rstN     (rstN),
    .wrStrobe (wrStrobe),
    .wrData   (wrData),
    .strobes  (strobes),
    .validOut (validOut),
    .dataOut  (dataOut)
  );

endmodule

// File: tb/wr_event_sync_bench.sv
module wr_event_sync_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;

  logic              sysClk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrStrobe = 1'b0;
  logic              chipSel = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic              validOut;
  logic [DATA_W-1:0] dataOut;

  int checks = 0;
  int errors = 0;
  string phaseTag = "R6";

  // Reference model state
  logic [DATA_W-1:0] dataLog[$];
  int                hist[$];
  logic              expValid = 1'b0;
  logic [DATA_W-1:0] expData = '0;

  wr_event_sync #(.DATA_W(DATA_W), .SYNC_DEPTH(3)) u_wr_event_sync (
    .sysClk   (sysClk),
    .rstN     (rstN),
    .wrStrobe (wrStrobe),
    .chipSel  (chipSel),
    .wrData   (wrData),
    .validOut (validOut),
    .dataOut  (dataOut)
  );

  always #(CLK_PERIOD/2) sysClk = ~sysClk;

  // Behavioural model: the valid pulse reflects the write count seen two
  // edges before this one against the count seen three edges before.
  always @(posedge sysClk) begin
    if (!rstN) begin
      hist = '{0, 0, 0, 0};
      expValid = 1'b0;
      expData = '0;
    end else begin
      hist.push_back(dataLog.size());
      if (hist.size() > 4) void'(hist.pop_front());
      expValid = (hist[1] % 2) != (hist[0] % 2);
      if (expValid) expData = dataLog[hist[1] - 1];
    end
  end

  // Compare on every cycle, away from the active edge.
  always @(negedge sysClk) begin
    checks++;
    if (validOut !== expValid) begin
      errors++;
      $display("FAIL R3 R4 %s validOut actual=%0b expected=%0b at %0t",
               phaseTag, validOut, expValid, $time);
    end
    checks++;
    if (dataOut !== expData) begin
      errors++;
      $display("FAIL R5 %s dataOut actual=%h expected=%h at %0t",
               phaseTag, dataOut, expData, $time);
    end
  end

  task automatic doWrite(input logic [DATA_W-1:0] d, input logic cs, input int gap);
    @(negedge sysClk);
    #1 wrData = d;
    chipSel = cs;
    #1 wrStrobe = 1'b1;
    if (cs) dataLog.push_back(d);
    #1 wrData = ~d;  // R7: disturbance after the capturing edge
    #1 wrStrobe = 1'b0;
    chipSel = 1'b0;
    repeat (gap) @(negedge sysClk);
  endtask

  task automatic doReset();
    @(negedge sysClk);
    rstN = 1'b0;
    dataLog.delete();
    repeat (3) @(negedge sysClk);
    rstN = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    phaseTag = "R6";
    repeat (4) @(negedge sysClk);
    rstN = 1'b1;
    repeat (6) @(negedge sysClk);

    phaseTag = "R1";
    doWrite(8'hA5, 1'b1, 8);
    doWrite(8'h00, 1'b1, 8);
    doWrite(8'hFF, 1'b1, 8);
    for (int i = 0; i < 5; i++) doWrite(8'(8'h11 * (i + 1)), 1'b1, 6);

    phaseTag = "R2";
    doWrite(8'h3C, 1'b0, 8);
    doWrite(8'hC3, 1'b0, 8);
    doWrite(8'h5A, 1'b1, 8);
    doWrite(8'h99, 1'b0, 8);

    phaseTag = "R4";
    for (int i = 0; i < 8; i++) doWrite(8'(8'h80 + i * 3), 1'b1, 3);
    repeat (8) @(negedge sysClk);

    phaseTag = "R7";
    doWrite(8'h0F, 1'b1, 8);
    doWrite(8'hF0, 1'b1, 8);

    phaseTag = "R6";
    doReset();
    repeat (10) @(negedge sysClk);
    doWrite(8'h42, 1'b1, 8);
    doWrite(8'h24, 1'b1, 8);

    repeat (10) @(negedge sysClk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule